// File: doc/BRIEF.md
# Half-Word-Lane Static Memory with Event-Triggered Read Sensing

This block is a clocked model of a 32-bit-wide static memory with a parameterized depth. Two chip enables select it: one is active-low and one is active-high. It also has an active-low write enable, an active-low output enable and two active-low half-word lane enables. The bidirectional data bus is split into a data input, a data output and one drive-enable per 16-bit lane. A parent module can therefore build the tristate pins, or merge several such memories on a shared bus, without a true tristate inside the block.

Reads are event-triggered. The array is sensed into an output latch only when a read trigger occurs:
- the chip becomes selected, or
- the address changes while the chip is selected and not writing.

Triggers that arrive in the same cycle merge into one sensing activity. Between triggers the latch holds its value, even when the array underneath it has changed. Each sensing activity opens a window of a configurable number of clock cycles. A new trigger while that window is open models the skew hazard: it starts a second sensing activity and sets a sticky error flag. Inputs are sampled on the rising clock edge. The lane drive-enables follow the control inputs combinationally.

Top module: `hws_sram`

## Requirements
- R1: The chip is selected only when `ce_ni`=0 and `ce_i`=1. While it is not selected, `doe_o` is 2'b00 for any value of the other inputs, and no write takes place.
- R2: When selected with `we_ni`=0, each enabled lane of `din_i` is stored at `addr_i` on the clock edge. `oe_ni` has no effect, and `doe_o` is 2'b00 for the whole write.
- R3: A lane is driven (`doe_o` bit set) only when the chip is selected, `oe_ni`=0, `we_ni`=1 and that lane is enabled. With `oe_ni`=1 the chip stays active but `doe_o` is 2'b00.
- R4: Lane enables: `hwe_ni[1]` governs bits 31:16 and drives `doe_o[1]`; `hwe_ni[0]` governs bits 15:0 and drives `doe_o[0]`. The codes `hwe_ni`=00, 01, 10 and 11 select both lanes, the upper lane only, the lower lane only, and no lane. Code 11 disables writing.
- R5: A read trigger occurs on an edge where the chip is selected and not writing, and either it was not selected on the previous edge or `addr_i` differs from its value on the previous edge. On that edge the full word at `addr_i` is captured into `dout_o`.
- R6: On an edge with no read trigger, `dout_o` keeps its value, even if the addressed word was rewritten meanwhile.
- R7: Each trigger opens a sense window of `SENSE_CYC` edges (default 1). A trigger while the window is open still updates `dout_o`, restarts the window and sets `err_o`. `err_o` stays 1 until reset.
- R8: Address changes during a write never update `dout_o`. The next read trigger at an address written earlier returns the newly written data.
- R9: Reset (`rst_ni`=0, asynchronous) clears `dout_o` and `err_o` to 0 but leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| ce_i | input | 1 | Chip enable, active high |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| hwe_ni | input | 2 | Lane enables, active low; [1] upper half, [0] lower half |
| addr_i | input | ADDR_W | Word address |
| din_i | input | 32 | Write data |
| dout_o | output | 32 | Sensed output latch |
| doe_o | output | 2 | Per-lane drive enable; [1] bits 31:16, [0] bits 15:0 |
| err_o | output | 1 | Sticky flag: trigger arrived inside an open sense window |

## Verification
The hardest case to reach is a stale output. The latch must hold an old word while the array below it holds new data. This needs a write to the currently latched address, followed by a return to reading with no select edge and no address change. The stimulus keeps the chip selected, writes to the latched address and moves the address during the write. It then releases write enable on the same address and checks that the old word persists. Two spaced address changes then show the new data. The re-trigger error is reached by changing the address on the edge right after a select edge, and a gap of one idle edge shows the non-error case.

// File: rtl/hws_pkg.sv
package hws_pkg;

  typedef struct packed {
    logic sel;  // both chip enables active
    logic wr;   // selected write
    logic rd;   // selected read with outputs enabled
  } hws_cmd_t;

  function automatic hws_cmd_t hws_decode(logic ce_n, logic ce, logic we_n, logic oe_n);
    hws_cmd_t c;
    c.sel = ~ce_n & ce;
    c.wr  = c.sel & ~we_n;
    c.rd  = c.sel & we_n & ~oe_n;
    return c;
  endfunction

endpackage

// File: rtl/hws_array.sv
module hws_array #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 16,
  parameter int LANES  = 2
) (
  input  logic                      clk_i,
  input  logic [LANES-1:0]          lane_we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  output logic [LANES*LANE_W-1:0]   rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  // One storage bank per lane keeps each bank single-driver.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk_i) begin
      if (lane_we_i[g]) bank[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = bank[addr_i];
  end

endmodule

// File: rtl/hws_lane_ctrl.sv
module hws_lane_ctrl #(
  parameter int LANES = 2
) (
  input  hws_pkg::hws_cmd_t cmd_i,
  input  logic [LANES-1:0]  hwe_ni,
  output logic [LANES-1:0]  lane_we_o,
  output logic [LANES-1:0]  doe_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      lane_we_o[g] = cmd_i.wr & ~hwe_ni[g];
      doe_o[g]     = cmd_i.rd & ~hwe_ni[g];
    end
  end

endmodule

// File: rtl/hws_trigger.sv
module hws_trigger #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              trig_o
);
  logic              sel_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      sel_q  <= sel_i;
      addr_q <= addr_i;
    end
  end

  // Select edge and address change merge into one request.
  always_comb begin
    trig_o = sel_i & ~wr_i & (~sel_q | (addr_i != addr_q));
  end

endmodule

// File: rtl/hws_sense.sv
module hws_sense #(
  parameter int DATA_W    = 32,
  parameter int SENSE_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              win_open_o,
  output logic              err_o
);
  localparam int CNT_W = $clog2(SENSE_CYC + 1);
  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(SENSE_CYC);

  logic [CNT_W-1:0] win_cnt;

  assign win_open_o = (win_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt <= '0;
      dout_o  <= '0;
      err_o   <= 1'b0;
    end else begin
      if (trig_i) begin
        win_cnt <= WIN_LOAD;
        dout_o  <= rdata_i;
        if (win_open_o) err_o <= 1'b1;
      end else if (win_open_o) begin
        win_cnt <= win_cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/hws_sram.sv
module hws_sram #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int LANE_W    = 16,
  parameter int SENSE_CYC = 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ce_ni,
  input  logic                          ce_i,
  input  logic                          we_ni,
  input  logic                          oe_ni,
  input  logic [DATA_W/LANE_W-1:0]      hwe_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             din_i,
  output logic [DATA_W-1:0]             dout_o,
  output logic [DATA_W/LANE_W-1:0]      doe_o,
  output logic                          err_o
);
  localparam int LANES = DATA_W / LANE_W;

  hws_pkg::hws_cmd_t cmd;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] rdata;
  logic              trig;
  logic              win_open;

  assign cmd = hws_pkg::hws_decode(ce_ni, ce_i, we_ni, oe_ni);

  hws_lane_ctrl #(.LANES(LANES)) u_lane (
    .cmd_i     (cmd),
    .hwe_ni    (hwe_ni),
    .lane_we_o (lane_we),
    .doe_o     (doe_o)
  );

  hws_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk_i     (clk_i),
    .lane_we_i (lane_we),
    .addr_i    (addr_i),
    .wdata_i   (din_i),
    .rdata_o   (rdata)
  );

  hws_trigger #(.ADDR_W(ADDR_W)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (cmd.sel),
    .wr_i   (cmd.wr),
    .addr_i (addr_i),
    .trig_o (trig)
  );

  hws_sense #(.DATA_W(DATA_W), .SENSE_CYC(SENSE_CYC)) u_sense (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig),
    .rdata_i    (rdata),
    .dout_o     (dout_o),
    .win_open_o (win_open),
    .err_o      (err_o)
  );

endmodule

// File: rtl/hws_sram_chk.sv
module hws_sram_chk #(
  parameter int DATA_W = 32,
  parameter int LANES  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              ce_i,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [LANES-1:0]  hwe_ni,
  input logic [DATA_W-1:0] dout_o,
  input logic [LANES-1:0]  doe_o,
  input logic              err_o,
  input logic              trig,
  input logic              win_open
);
  logic sel;
  assign sel = ~ce_ni & ce_i;

  AST_DESELECT_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |-> doe_o == '0);  // R1
  AST_WRITE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !we_ni) |-> doe_o == '0);  // R2
  AST_OE_OFF_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> doe_o == '0);  // R3
  AST_NO_LANE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&hwe_ni) |-> doe_o == '0);  // R4
  AST_STALE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig |=> $stable(dout_o));  // R6
  AST_RETRIG_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && win_open) |=> err_o);  // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);  // R7
  AST_WRITE_NO_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !we_ni) |-> !trig);  // R8

endmodule

bind hws_sram hws_sram_chk #(.DATA_W(DATA_W), .LANES(DATA_W/LANE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_ni    (ce_ni),
  .ce_i     (ce_i),
  .we_ni    (we_ni),
  .oe_ni    (oe_ni),
  .hwe_ni   (hwe_ni),
  .dout_o   (dout_o),
  .doe_o    (doe_o),
  .err_o    (err_o),
  .trig     (trig),
  .win_open (win_open)
);

// File: tb/hws_sram_test.sv
module hws_sram_test;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ce_ni = 1'b1, ce_i = 1'b0, we_ni = 1'b1, oe_ni = 1'b1;
  logic [1:0]        hwe_ni = 2'b11;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       din_i = '0;
  logic [31:0]       dout_o;
  logic [1:0]        doe_o;
  logic              err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hws_sram #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .ce_i(ce_i), .we_ni(we_ni),
    .oe_ni(oe_ni), .hwe_ni(hwe_ni), .addr_i(addr_i), .din_i(din_i),
    .dout_o(dout_o), .doe_o(doe_o), .err_o(err_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic deselect();
    ce_ni = 1'b1; we_ni = 1'b1; oe_ni = 1'b1;
  endtask

  // Selected write with oe low to show it is ignored (R2)
  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d, logic [1:0] h);
    ce_ni = 1'b0; ce_i = 1'b1; we_ni = 1'b0; oe_ni = 1'b0;
    addr_i = a; din_i = d; hwe_ni = h;
    #1 check("R2 doe during write", {30'd0, doe_o}, 32'd0);
    step();
    deselect();
    step();
  endtask

  // Select edge read; leaves chip selected
  task automatic rd_sel(logic [ADDR_W-1:0] a);
    ce_ni = 1'b0; ce_i = 1'b1; we_ni = 1'b1; oe_ni = 1'b0;
    addr_i = a; hwe_ni = 2'b00;
    step();
  endtask

  task automatic t_reset();
    check("R9 dout after reset", dout_o, 32'd0);
    check("R9 err after reset", {31'd0, err_o}, 32'd0);
    check("R1 doe after reset", {30'd0, doe_o}, 32'd0);
  endtask

  task automatic t_deselect();
    ce_ni = 1'b0; ce_i = 1'b0; we_ni = 1'b1; oe_ni = 1'b0; hwe_ni = 2'b00;
    #1 check("R1 high enable off", {30'd0, doe_o}, 32'd0);
    ce_ni = 1'b1; ce_i = 1'b1;
    #1 check("R1 low enable off", {30'd0, doe_o}, 32'd0);
    // deselected write attempt must not store
    ce_ni = 1'b1; ce_i = 1'b1; we_ni = 1'b0; addr_i = 10'd3; din_i = 32'hDEAD_DEAD;
    step();
    deselect();
    step();
    wr(10'd3, 32'h0000_0033, 2'b00);
    ce_ni = 1'b1; ce_i = 1'b1; we_ni = 1'b0; din_i = 32'hBAD0_BAD0;
    step();
    deselect();
    step();
    rd_sel(10'd3);
    check("R1 deselected write ignored", dout_o, 32'h0000_0033);
    deselect();
    step();
  endtask

  task automatic t_lanes();
    wr(10'd5, 32'hA5A5_1234, 2'b00);
    wr(10'd5, 32'hFFFF_FFFF, 2'b01);
    wr(10'd5, 32'h0000_0000, 2'b11);
    wr(10'd5, 32'h0000_BEEF, 2'b10);
    rd_sel(10'd5);
    check("R4 lane merge read", dout_o, 32'hFFFF_BEEF);
    check("R3 both lanes driven", {30'd0, doe_o}, 32'd3);
    hwe_ni = 2'b01;
    #1 check("R4 upper only", {30'd0, doe_o}, 32'd2);
    hwe_ni = 2'b10;
    #1 check("R4 lower only", {30'd0, doe_o}, 32'd1);
    hwe_ni = 2'b11;
    #1 check("R4 no lane", {30'd0, doe_o}, 32'd0);
    hwe_ni = 2'b00; oe_ni = 1'b1;
    #1 check("R3 oe high disables", {30'd0, doe_o}, 32'd0);
    deselect();
    step();
  endtask

  task automatic t_window();
    wr(10'd20, 32'h1111_1111, 2'b00);
    wr(10'd21, 32'h2222_2222, 2'b00);
    rd_sel(10'd20);
    check("R5 select trigger", dout_o, 32'h1111_1111);
    step();
    addr_i = 10'd21;
    step();
    check("R5 address trigger", dout_o, 32'h2222_2222);
    check("R7 spaced triggers no error", {31'd0, err_o}, 32'd0);
    deselect();
    step();
    rd_sel(10'd20);
    addr_i = 10'd21;
    step();
    check("R7 retrigger updates latch", dout_o, 32'h2222_2222);
    check("R7 retrigger sets error", {31'd0, err_o}, 32'd1);
    deselect();
    step();
    step();
    check("R7 error sticky", {31'd0, err_o}, 32'd1);
  endtask

  task automatic t_reset_keep();
    rst_ni = 1'b0;
    #1 check("R9 err cleared", {31'd0, err_o}, 32'd0);
    check("R9 dout cleared", dout_o, 32'd0);
    step();
    rst_ni = 1'b1;
    step();
    rd_sel(10'd5);
    check("R9 contents kept", dout_o, 32'hFFFF_BEEF);
    deselect();
    step();
  endtask

  task automatic t_stale();
    wr(10'd30, 32'hAAAA_0001, 2'b00);
    wr(10'd31, 32'hBBBB_0002, 2'b00);
    rd_sel(10'd30);
    check("R5 read before write", dout_o, 32'hAAAA_0001);
    step();
    we_ni = 1'b0; din_i = 32'hCCCC_0003;
    step();
    check("R8 write same address", dout_o, 32'hAAAA_0001);
    check("R2 doe during selected write", {30'd0, doe_o}, 32'd0);
    addr_i = 10'd31; din_i = 32'hDDDD_0004;
    step();
    check("R8 address change in write", dout_o, 32'hAAAA_0001);
    we_ni = 1'b1;
    step();
    check("R6 stale word persists", dout_o, 32'hAAAA_0001);
    check("R3 stale word driven", {30'd0, doe_o}, 32'd3);
    addr_i = 10'd30;
    step();
    check("R8 new data on trigger", dout_o, 32'hCCCC_0003);
    step();
    addr_i = 10'd31;
    step();
    check("R8 second written word", dout_o, 32'hDDDD_0004);
    check("R7 no error after spaced", {31'd0, err_o}, 32'd0);
    deselect();
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_deselect();
    t_lanes();
    t_window();
    t_reset_keep();
    t_stale();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule